// File: doc/BRIEF.md
# Radix-4 Booth Sequential Multiplier

This block multiplies two signed two's-complement operands of N bits and returns a signed product of 2N bits. It works through the multiplier operand two bits at a time. In each clocked step it reads a three-bit window of the multiplier. The window overlaps the previous one by one bit, and a zero bit is assumed below the least significant bit. The step turns the window into one of five actions: add nothing, add or subtract the multiplicand, or add or subtract twice the multiplicand. The chosen multiple sits at the weight of the current bit pair and goes into a 2N-bit accumulator. One shared adder does every step, and a subtraction adds the inverted multiple plus one. A complete product therefore takes N/2 steps rather than N.

A caller pulses `start` with the operands on `x` and `y`. The block captures them and clears its accumulator. `done` pulses once when the last step has retired, and `product` then holds the result until the next accepted start. While a product is being formed, further starts are dropped.

Top module: `booth_seq_mul`

## Requirements
- R1: When `done` is high, `product` equals the signed product of the `x` and `y` captured at the accepted start, as a 2N-bit two's-complement value.
- R2: If a start is accepted at clock edge t, `done` is high in the cycle that follows edge t+N/2. For the default N=8, that is four edges later.
- R3: `done` is high for exactly one cycle per accepted start.
- R4: A `start` that arrives while a product is still being formed is ignored. The running operation finishes with its original operands and at its original time.
- R5: The multiplier is recoded from windows formed by bit 2k+1, bit 2k and bit 2k-1 of y, where bit -1 is 0. Windows 000 and 111 add zero. Windows 001 and 010 add x. Window 011 adds 2x. Window 100 subtracts 2x. Windows 101 and 110 subtract x. Each multiple is weighted by 4^k. For example, y = -1 gives -x, and 25 times -18 gives -450.
- R6: After reset, `product` is 0 and `done` is 0.
- R7: After `done`, `product` keeps its value until the next accepted start.
- R8: The most negative operand times itself gives +2^(2N-2), with no overflow in the 2N-bit result.
- R9: A zero operand on either side gives a product of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a multiplication; accepted only when idle |
| x | input | N | Signed multiplicand, sampled on an accepted start |
| y | input | N | Signed multiplier, sampled on an accepted start |
| product | output | 2N | Signed product; running partial sum while busy |
| done | output | 1 | One-cycle pulse when the product is complete |

## Verification
The assertions assume that `start`, `x` and `y` carry known values at every rising edge after reset. They also assume that N is even, so the window steps cover the multiplier exactly. Operands matter only on the edge where a start is accepted, so the bench changes them freely at other times. It drives every input half a period away from the rising edge. It sends one extra start into the middle of a running operation to exercise the ignore path, and otherwise waits for `done` before it issues the next request.

// File: rtl/booth_seq_mul.sv
module booth_seq_mul #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N-1:0]   x,
  input  logic [N-1:0]   y,
  output logic [2*N-1:0] product,
  output logic           done
);
  localparam int W     = 2 * N;
  localparam int STEPS = N / 2;
  localparam int CW    = (STEPS > 1) ? $clog2(STEPS) : 1;

  logic          busy;
  logic [CW-1:0] step;
  logic [W-1:0]  mc;
  logic [N:0]    yr;
  logic [W-1:0]  acc;
  logic [W-1:0]  pick;
  logic          neg;
  logic [W-1:0]  sum;
  logic          last;
  logic          accept;

  assign accept = start && !busy;
  assign last   = (step == CW'(STEPS - 1));

  always_comb begin
    pick = '0;
    neg  = 1'b0;
    unique case (yr[2:0])
      3'b001, 3'b010: pick = mc;
      3'b011:         pick = mc << 1;
      3'b100: begin   pick = mc << 1; neg = 1'b1; end
      3'b101, 3'b110: begin pick = mc; neg = 1'b1; end
      default: ;
    endcase
  end

  assign sum     = acc + (neg ? ~pick : pick) + W'(neg);
  assign product = acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      step <= '0;
      mc   <= '0;
      yr   <= '0;
      acc  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy <= 1'b1;
        step <= '0;
        mc   <= {{N{x[N-1]}}, x};
        yr   <= {y, 1'b0};
        acc  <= '0;
      end else if (busy) begin
        acc  <= sum;
        mc   <= mc << 2;
        yr   <= {{2{yr[N]}}, yr[N:2]};
        step <= step + CW'(1);
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  logic signed [N-1:0] xo, yo;
  logic signed [W-1:0] ref_p;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xo <= '0;
      yo <= '0;
    end else if (accept) begin
      xo <= x;
      yo <= y;
    end
  end
  assign ref_p = W'(xo) * W'(yo);

  p_product_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (product == ref_p));

  p_done_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && last) |=> (done && !busy));

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_start_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !last) |=> (busy && step == $past(step) + CW'(1)));

  p_product_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product));
endmodule

// File: tb/tb_booth_seq_mul.sv
module tb_booth_seq_mul;
  localparam int N = 8;
  localparam int W = 2 * N;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [N-1:0] x = '0, y = '0;
  logic [W-1:0] product;
  logic done;

  booth_seq_mul #(.N(N)) dut (.clk(clk), .rst_n(rst_n), .start(start),
    .x(x), .y(y), .product(product), .done(done));

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, start_cyc = 0;
  logic [W-1:0] expq[$];
  logic [W-1:0] last_exp = '0;
  logic prev_done = 1'b0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) if (cyc > 100000) begin
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        if (expq.size() == 0) chk(1'b0, "R3 unexpected done", product, '0);
        else begin
          last_exp = expq.pop_front();
          chk(product == last_exp, "R1/R5 product", product, last_exp);
          chk(cyc - start_cyc == N/2, "R2 latency", W'(cyc - start_cyc), W'(N/2));
        end
      end
      if (done && prev_done) chk(1'b0, "R3 done width", W'(1), W'(0));
      prev_done = done;
    end
  end

  task automatic run_op(input logic [N-1:0] a, input logic [N-1:0] b, input bit intrude);
    logic signed [W-1:0] e;
    e = W'($signed(a)) * W'($signed(b));
    expq.push_back(e);
    @(negedge clk);
    x = a; y = b; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    start_cyc = cyc;
    x = ~a; y = b + 8'd3;
    if (intrude) begin
      @(negedge clk);
      start = 1'b1; x = 8'h7f; y = 8'h55;   // R4: must be ignored
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(product == '0, "R6 reset product", product, '0);
    chk(done == 1'b0, "R6 reset done", W'(done), '0);
    rst_n = 1'b1;
    @(negedge clk);

    run_op(8'd25, -8'sd18, 1'b0);        // R5 worked vector, -450
    run_op(8'h80, 8'h80, 1'b0);          // R8 most negative squared
    run_op(8'h80, 8'hff, 1'b0);          // R8 most negative times -1
    run_op(8'h5a, 8'h00, 1'b0);          // R9 zero multiplier
    run_op(8'h00, 8'h93, 1'b0);          // R9 zero multiplicand
    run_op(8'h37, 8'hff, 1'b0);          // R5 all-ones windows give -x
    run_op(8'h7f, 8'h7f, 1'b0);          // R5 max positive
    run_op(8'hc3, 8'h55, 1'b0);          // R5 alternating windows
    run_op(8'h2d, 8'haa, 1'b0);          // R5 window 100 paths
    run_op(8'h81, 8'h33, 1'b1);          // R4 start while busy

    repeat (3) @(negedge clk);
    chk(product == last_exp, "R7 hold after done", product, last_exp);
    chk(done == 1'b0, "R3 no extra done", W'(done), '0);

    for (int i = 0; i < 40; i++)
      run_op(N'($urandom), N'($urandom), 1'b0);   // R1 random pairs

    repeat (2) @(negedge clk);
    chk(expq.size() == 0, "R1 scoreboard drained", W'(expq.size()), '0);
    summary();
  end
endmodule